// File: doc/BRIEF.md
# Broadcast Storm Limiter

This block decides, frame by frame, whether a received frame may enter the switch's buffer memory when that frame would be flooded to many ports. Each frame's destination address is presented with the result of the address-table lookup. The block sorts the frame into one of four classes. Three of those classes count as broadcast-class: the all-ones address, any group address, and a unicast address the table does not know. A fourth class, a known unicast address, is never limited.

A saturating occupancy counter tracks how many broadcast-class frames are held in memory. The buffer manager sends a stored strobe and a released strobe, each tagged with the frame's class. A programmable limit sets how many broadcast-class frames may be resident at once. When the resident count has reached the limit, new broadcast-class frames are rejected until a release frees a slot. A limit of zero turns the restriction off. The verdict and the class code are registered, and they appear one cycle after the frame is presented.

Top module: `bsl_storm_limiter`

## Requirements
- R1: A destination of all ones is broadcast-class. It reports class code 1 (`dec_cls_o`) whether or not the lookup hit.
- R2: The group bit is bit 0 of the first destination octet. The first octet is `frm_da_i[47:40]`, so the group bit is `frm_da_i[40]`. A destination with this bit set, other than all ones, is broadcast-class with class code 2. No other bit makes a destination a group address.
- R3: A unicast destination (group bit clear) with `frm_hit_i` low is broadcast-class with class code 3. With `frm_hit_i` high it is class code 0 and is not broadcast-class.
- R4: Frames of class code 0 are always accepted, whatever the occupancy and the limit.
- R5: A broadcast-class frame is accepted when the limit is zero or the occupancy is below the limit. Otherwise it is dropped (`dec_accept_o` low).
- R6: Results are registered. `dec_vld_o`, `dec_accept_o`, `dec_bc_o` and `dec_cls_o` reflect the frame presented with `frm_vld_i` at the previous rising edge. The verdict is judged against the occupancy and the limit as they were before that edge.
- R7: The occupancy (`bc_count_o`) rises by one on a stored strobe tagged broadcast-class and falls by one on a released strobe tagged broadcast-class. When both come in the same cycle, the occupancy is unchanged. The new value is visible after the edge.
- R8: The occupancy holds at zero on a release and at its maximum value (255 by default) on a store.
- R9: Stored or released strobes whose broadcast-class tag is low leave the occupancy unchanged.
- R10: A write (`lim_we_i`) loads the limit from `lim_wdata_i`. The new limit governs frames presented after the write edge.
- R11: After reset the occupancy is 0, the limit is 0, and `dec_vld_o` and `dec_accept_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_vld_i | input | 1 | A frame's destination is presented this cycle |
| frm_da_i | input | 48 | Destination address, first octet in bits 47:40 |
| frm_hit_i | input | 1 | Address table knows this destination |
| store_i | input | 1 | A frame was written into buffer memory |
| store_bc_i | input | 1 | The stored frame is broadcast-class |
| rel_i | input | 1 | A frame was freed from buffer memory |
| rel_bc_i | input | 1 | The freed frame is broadcast-class |
| lim_we_i | input | 1 | Write strobe for the limit register |
| lim_wdata_i | input | 8 | New limit value |
| dec_vld_o | output | 1 | A verdict is valid this cycle |
| dec_accept_o | output | 1 | Frame may be stored |
| dec_bc_o | output | 1 | Frame is broadcast-class |
| dec_cls_o | output | 2 | Class: 0 known unicast, 1 all ones, 2 group, 3 unknown unicast |
| bc_count_o | output | 8 | Broadcast-class frames resident in memory |

## Verification
The bench drives every input on the falling edge. A verdict is due one rising edge after its frame is presented, and an occupancy change is due one rising edge after its strobe. The bench therefore samples at the next falling edge, which lies half a cycle after the register that produces the value. A limit write is made in its own cycle, and the frames it should govern are presented only afterwards. The limit scenarios first fill the counter with stores and only then present frames, so every verdict is judged against a count the bench already holds. The bench saturates the counter by issuing more stores than its range and then drains it fully, which covers both ends of the counter.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  localparam int unsigned DA_W  = 48;
  localparam int unsigned CNT_W = 8;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_ONES  = 2'd1,
    CLS_GROUP = 2'd2,
    CLS_FLOOD = 2'd3
  } frm_cls_e;
endpackage

// File: rtl/bsl_classify.sv
module bsl_classify
  import bsl_pkg::*;
#(
  parameter int unsigned DA_W_P = DA_W
) (
  input  logic [DA_W_P-1:0] da_i,
  input  logic              hit_i,
  output frm_cls_e          cls_o,
  output logic              bc_o
);
  // group bit: LSB of the first (most significant) octet
  localparam int unsigned GRP_BIT = DA_W_P - 8;

  always_comb begin
    if (&da_i)             cls_o = CLS_ONES;
    else if (da_i[GRP_BIT]) cls_o = CLS_GROUP;
    else if (!hit_i)        cls_o = CLS_FLOOD;
    else                    cls_o = CLS_UCAST;
    bc_o = (cls_o != CLS_UCAST);
  end
endmodule

// File: rtl/bsl_occ_counter.sv
module bsl_occ_counter #(
  parameter int unsigned CNT_W_P = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               inc_i,
  input  logic               dec_i,
  output logic [CNT_W_P-1:0] cnt_o
);
  localparam logic [CNT_W_P-1:0] CNT_MAX = {CNT_W_P{1'b1}};

  logic [CNT_W_P-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_q));
  p_sat_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> (cnt_q == '0));
  p_sat_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/bsl_admit.sv
module bsl_admit
  import bsl_pkg::*;
#(
  parameter int unsigned CNT_W_P = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  frm_cls_e           cls_i,
  input  logic               bc_i,
  input  logic [CNT_W_P-1:0] cnt_i,
  input  logic [CNT_W_P-1:0] lim_i,
  output logic               vld_o,
  output logic               accept_o,
  output logic               bc_o,
  output frm_cls_e           cls_o
);
  logic room;
  logic accept_d;

  always_comb begin
    room     = (lim_i == '0) || (cnt_i < lim_i);
    accept_d = !bc_i || room;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      accept_o <= 1'b0;
      bc_o     <= 1'b0;
      cls_o    <= CLS_UCAST;
    end else begin
      vld_o    <= vld_i;
      accept_o <= vld_i && accept_d;
      bc_o     <= vld_i && bc_i;
      cls_o    <= vld_i ? cls_i : CLS_UCAST;
    end
  end

  p_ucast_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && cls_i == CLS_UCAST) |=> (vld_o && accept_o));
  p_drop_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && bc_i && lim_i != '0 && cnt_i >= lim_i) |=> !accept_o);
  p_no_limit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && lim_i == '0) |=> accept_o);
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!vld_o && !accept_o));
endmodule

// File: rtl/bsl_storm_limiter.sv
module bsl_storm_limiter
  import bsl_pkg::*;
#(
  parameter int unsigned DA_W_P  = DA_W,
  parameter int unsigned CNT_W_P = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frm_vld_i,
  input  logic [DA_W_P-1:0]  frm_da_i,
  input  logic               frm_hit_i,
  input  logic               store_i,
  input  logic               store_bc_i,
  input  logic               rel_i,
  input  logic               rel_bc_i,
  input  logic               lim_we_i,
  input  logic [CNT_W_P-1:0] lim_wdata_i,
  output logic               dec_vld_o,
  output logic               dec_accept_o,
  output logic               dec_bc_o,
  output logic [1:0]         dec_cls_o,
  output logic [CNT_W_P-1:0] bc_count_o
);
  frm_cls_e           cls_w, cls_q;
  logic               bc_w;
  logic [CNT_W_P-1:0] lim_q;
  logic [CNT_W_P-1:0] cnt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lim_q <= '0;
    else if (lim_we_i) lim_q <= lim_wdata_i;
  end

  bsl_classify #(.DA_W_P(DA_W_P)) u_cls (
    .da_i  (frm_da_i),
    .hit_i (frm_hit_i),
    .cls_o (cls_w),
    .bc_o  (bc_w)
  );

  bsl_occ_counter #(.CNT_W_P(CNT_W_P)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (store_i && store_bc_i),
    .dec_i  (rel_i && rel_bc_i),
    .cnt_o  (cnt_w)
  );

  bsl_admit #(.CNT_W_P(CNT_W_P)) u_adm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (frm_vld_i),
    .cls_i    (cls_w),
    .bc_i     (bc_w),
    .cnt_i    (cnt_w),
    .lim_i    (lim_q),
    .vld_o    (dec_vld_o),
    .accept_o (dec_accept_o),
    .bc_o     (dec_bc_o),
    .cls_o    (cls_q)
  );

  assign dec_cls_o  = cls_q;
  assign bc_count_o = cnt_w;

  p_ones_cls_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && (&frm_da_i)) |=> (dec_bc_o && dec_cls_o == 2'd1));
  p_lim_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_we_i |=> (lim_q == $past(lim_wdata_i)));
endmodule

// File: tb/bsl_storm_limiter_test.sv
module bsl_storm_limiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_vld = 1'b0;
  logic [47:0] frm_da = '0;
  logic        frm_hit = 1'b0;
  logic        store = 1'b0, store_bc = 1'b0, rel = 1'b0, rel_bc = 1'b0;
  logic        lim_we = 1'b0;
  logic [7:0]  lim_wdata = '0;
  logic        dec_vld, dec_accept, dec_bc;
  logic [1:0]  dec_cls;
  logic [7:0]  bc_count;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bsl_storm_limiter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .frm_vld_i(frm_vld), .frm_da_i(frm_da), .frm_hit_i(frm_hit),
    .store_i(store), .store_bc_i(store_bc), .rel_i(rel), .rel_bc_i(rel_bc),
    .lim_we_i(lim_we), .lim_wdata_i(lim_wdata),
    .dec_vld_o(dec_vld), .dec_accept_o(dec_accept), .dec_bc_o(dec_bc),
    .dec_cls_o(dec_cls), .bc_count_o(bc_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present a frame, sample verdict one edge later
  task automatic frame(input logic [47:0] da, input logic hit,
                       input int exp_acc, input int exp_bc, input int exp_cls,
                       input string req);
    @(negedge clk);
    frm_vld = 1'b1; frm_da = da; frm_hit = hit;
    @(negedge clk);
    frm_vld = 1'b0;
    chk({req, " vld"}, int'(dec_vld), 1);
    chk({req, " accept"}, int'(dec_accept), exp_acc);
    chk({req, " bc"}, int'(dec_bc), exp_bc);
    chk({req, " cls"}, int'(dec_cls), exp_cls);
  endtask

  task automatic strobe(input logic s, input logic sbc, input logic r, input logic rbc);
    @(negedge clk);
    store = s; store_bc = sbc; rel = r; rel_bc = rbc;
    @(negedge clk);
    store = 1'b0; store_bc = 1'b0; rel = 1'b0; rel_bc = 1'b0;
  endtask

  task automatic set_lim(input logic [7:0] v);
    @(negedge clk);
    lim_we = 1'b1; lim_wdata = v;
    @(negedge clk);
    lim_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 count", int'(bc_count), 0);
    chk("R11 vld", int'(dec_vld), 0);
    chk("R11 accept", int'(dec_accept), 0);
    // limit zero after reset: full counter would still admit
  endtask

  task automatic t_classify();
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 1, 1, 1, "R1 ones hit");
    frame(48'hFFFF_FFFF_FFFF, 1'b0, 1, 1, 1, "R1 ones miss");
    frame(48'h0100_5E00_0001, 1'b1, 1, 1, 2, "R2 group hit");
    frame(48'hFF00_0000_0000, 1'b0, 1, 1, 2, "R2 group miss");
    frame(48'hFEFF_FFFF_FFFF, 1'b1, 1, 0, 0, "R2 other bits");
    frame(48'h0011_2233_4455, 1'b0, 1, 1, 3, "R3 unknown");
    frame(48'h0011_2233_4455, 1'b1, 1, 0, 0, "R3 known");
    // R6: idle cycle after a frame drops valid
    @(negedge clk);
    chk("R6 idle vld", int'(dec_vld), 0);
  endtask

  task automatic t_counter();
    strobe(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 inc", int'(bc_count), 1);
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 store untagged", int'(bc_count), 1);
    strobe(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 rel untagged", int'(bc_count), 1);
    strobe(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R7 both", int'(bc_count), 1);
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 dec", int'(bc_count), 0);
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 floor", int'(bc_count), 0);
  endtask

  task automatic t_limit();
    set_lim(8'd2);
    strobe(1'b1, 1'b1, 1'b0, 1'b0);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 1, 1, 1, "R5 below limit");
    strobe(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 count two", int'(bc_count), 2);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 0, 1, 1, "R5 at limit ones");
    frame(48'h0300_0000_0000, 1'b1, 0, 1, 2, "R5 at limit group");
    frame(48'h0011_2233_4455, 1'b0, 0, 1, 3, "R5 at limit unknown");
    frame(48'h0011_2233_4455, 1'b1, 1, 0, 0, "R4 ucast at limit");
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 1, 1, 1, "R5 after release");
    strobe(1'b1, 1'b1, 1'b0, 1'b0);
    set_lim(8'd0);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 1, 1, 1, "R10 limit off");
    set_lim(8'd3);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 1, 1, 1, "R10 raised limit");
    set_lim(8'd1);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 0, 1, 1, "R10 lowered limit");
    // R6: verdict uses count before the edge a store lands on
    set_lim(8'd3);
    @(negedge clk);
    frm_vld = 1'b1; frm_da = '1; frm_hit = 1'b1;
    store = 1'b1; store_bc = 1'b1;
    @(negedge clk);
    frm_vld = 1'b0; store = 1'b0; store_bc = 1'b0;
    chk("R6 pre-edge count", int'(dec_accept), 1);
    chk("R6 count three", int'(bc_count), 3);
    frame(48'hFFFF_FFFF_FFFF, 1'b1, 0, 1, 1, "R6 now full");
    for (int i = 0; i < 3; i++) strobe(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 drained", int'(bc_count), 0);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    store = 1'b1; store_bc = 1'b1;
    for (int i = 0; i < 300; i++) @(negedge clk);
    store = 1'b0; store_bc = 1'b0;
    chk("R8 ceiling", int'(bc_count), 255);
    rel = 1'b1; rel_bc = 1'b1;
    for (int i = 0; i < 254; i++) @(negedge clk);
    chk("R8 near floor", int'(bc_count), 1);
    for (int i = 0; i < 5; i++) @(negedge clk);
    rel = 1'b0; rel_bc = 1'b0;
    chk("R8 floor again", int'(bc_count), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_classify();
    t_counter();
    t_limit();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule